// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a system watchdog with two stages. A down-counter steps on an external periodic tick. When it runs out, the block can raise a one-cycle system-management interrupt request and sets a sticky first-timeout flag. If software does not service the timer before the next run-out, the second expiry drives a system reset. A no-reboot control bit can hold that reset back.

Software reaches the timer through a register window of 32 bytes on a simple synchronous register bus. Writes take effect on a clock edge and reads are combinational. Byte offsets inside the window are:

| Offset | Register | Access |
|---|---|---|
| 0x00 | kick | A write restarts the countdown. A read returns the live count. |
| 0x04 | period | Read/write timeout value. |
| 0x08 | status | Bit 0 is the first-timeout flag. Writing 1 clears it. |
| 0x0C | control | Bit 0 enables the interrupt, bit 1 is no-reboot, bit 2 is halt. |

Other offsets read as zero and ignore writes.

Top module: `sentinel_wdt`

## Requirements
- R1: After reset the count and the period both read PERIOD_INIT. Control reads 0x4, with only halt set. Status reads 0. smiReq and sysRst are low.
- R2: While halt (control bit 2) is clear, each cycle with tick high lowers the count by one.
- R3: A tick that arrives while the count is zero is an expiry. The count then loads the period, so after a kick with period P the (P+1)-th tick expires.
- R4: Each expiry raises smiReq for exactly the one cycle after the expiring tick, and only when control bit 0 is set.
- R5: Every expiry sets status bit 0. Writing 1 to status bit 0 clears it. Writing 0 to status bit 0 leaves it unchanged.
- R6: An expiry while status bit 0 is already set drives sysRst high. sysRst then stays high until rstN is asserted.
- R7: While control bit 1 (no-reboot) is set, a second expiry does not assert sysRst.
- R8: Any write to offset 0x00 loads the count from the period and clears status bit 0. The next expiry after that is therefore a first timeout.
- R9: While halt is set, ticks leave the count unchanged and no expiry occurs.
- R10: A kick write in the same cycle as a tick at count zero takes priority. The count reloads, no interrupt is raised and status bit 0 stays clear.
- R11: The period register at 0x04 is read/write. A new value takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Periodic count-enable pulse |
| busWe | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Byte offset in the window |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr |
| smiReq | output | 1 | One-cycle interrupt request per expiry |
| sysRst | output | 1 | Sticky system reset request |

## Verification
The hardest case to reach is a kick write that lands in the same cycle as the tick that would expire the counter. The stimulus brings the count to zero with a short period. It then raises tick and the kick write together in one cycle and checks that neither the interrupt nor the flag appears. Reaching the reset path takes two full expiry periods with no kick in between, and the test repeats this with no-reboot set.

// File: rtl/sentinel_wdt_pkg.sv
package sentinel_wdt_pkg;
  // byte offsets inside the register window
  localparam int OFS_KICK   = 'h00;
  localparam int OFS_PERIOD = 'h04;
  localparam int OFS_STATUS = 'h08;
  localparam int OFS_CTRL   = 'h0C;

  // control bit positions
  localparam int CTL_SMI_EN    = 0;
  localparam int CTL_NO_REBOOT = 1;
  localparam int CTL_HALT      = 2;

  // strobes from the register side to the counter
  typedef struct packed {
    logic reload;
    logic run;
  } dpCmd_t;
endpackage

// File: rtl/sentinel_wdt_count.sv
module sentinel_wdt_count
  import sentinel_wdt_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int PERIOD_INIT = 1023
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  dpCmd_t           cmd,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic atZero;
  assign atZero = (cnt == '0);
  // a reload write masks the expiring tick
  assign expire = tick && cmd.run && !cmd.reload && atZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     cnt <= CNT_W'(PERIOD_INIT);
    else if (cmd.reload || expire) cnt <= period;
    else if (tick && cmd.run)      cnt <= cnt - 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cmd.run && !cmd.reload && !atZero) |=> (cnt == $past(cnt) - 1'b1)); // R2
  AST_EXPIRE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (cnt == $past(period))); // R3
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.run && !cmd.reload) |=> $stable(cnt)); // R9
  AST_KICK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    cmd.reload |=> (cnt == $past(period))); // R8
endmodule

// File: rtl/sentinel_wdt_regs.sv
module sentinel_wdt_regs
  import sentinel_wdt_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 10,
  parameter int PERIOD_INIT = 1023
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              expire,
  output dpCmd_t            cmd,
  output logic [CNT_W-1:0]  period,
  output logic              smiReq,
  output logic              sysRst
);
  logic smiEn, noReboot, halt, firstTo;
  logic selKick, selPeriod, selStatus, selCtrl;
  logic wrKick, wrPeriod, wrStatus, wrCtrl;

  assign selKick   = (busAddr == ADDR_W'(OFS_KICK));
  assign selPeriod = (busAddr == ADDR_W'(OFS_PERIOD));
  assign selStatus = (busAddr == ADDR_W'(OFS_STATUS));
  assign selCtrl   = (busAddr == ADDR_W'(OFS_CTRL));

  assign wrKick   = busWe && selKick;
  assign wrPeriod = busWe && selPeriod;
  assign wrStatus = busWe && selStatus;
  assign wrCtrl   = busWe && selCtrl;

  assign cmd.reload = wrKick;
  assign cmd.run    = !halt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      period   <= CNT_W'(PERIOD_INIT);
      smiEn    <= 1'b0;
      noReboot <= 1'b0;
      halt     <= 1'b1;
    end else begin
      if (wrPeriod) period <= busWdata[CNT_W-1:0];
      if (wrCtrl) begin
        smiEn    <= busWdata[CTL_SMI_EN];
        noReboot <= busWdata[CTL_NO_REBOOT];
        halt     <= busWdata[CTL_HALT];
      end
    end
  end

  // expiry tracking, interrupt pulse and sticky reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstTo <= 1'b0;
      smiReq  <= 1'b0;
      sysRst  <= 1'b0;
    end else begin
      smiReq <= expire && smiEn;
      if (expire && firstTo && !noReboot) sysRst <= 1'b1;
      if (expire)                         firstTo <= 1'b1;
      else if (wrKick)                    firstTo <= 1'b0;
      else if (wrStatus && busWdata[0])   firstTo <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    if (selKick)   busRdata = DATA_W'(cnt);
    if (selPeriod) busRdata = DATA_W'(period);
    if (selStatus) busRdata[0] = firstTo;
    if (selCtrl) begin
      busRdata[CTL_SMI_EN]    = smiEn;
      busRdata[CTL_NO_REBOOT] = noReboot;
      busRdata[CTL_HALT]      = halt;
    end
  end

  AST_SMI_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    smiReq |-> $past(expire)); // R4
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> firstTo); // R5
  AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    sysRst |=> sysRst); // R6
  AST_RST_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRst) |-> $past(firstTo)); // R6
  AST_NO_REBOOT_BLOCK: assert property (@(posedge clk) disable iff (!rstN)
    (!sysRst && noReboot) |=> !sysRst); // R7
endmodule

// File: rtl/sentinel_wdt.sv
module sentinel_wdt
  import sentinel_wdt_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 10,
  parameter int PERIOD_INIT = 1023
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              smiReq,
  output logic              sysRst
);
  dpCmd_t           cmd;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] cnt;
  logic             expire;

  sentinel_wdt_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PERIOD_INIT(PERIOD_INIT)
  ) u_regs (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .cnt(cnt), .expire(expire),
    .cmd(cmd), .period(period), .smiReq(smiReq), .sysRst(sysRst)
  );

  sentinel_wdt_count #(
    .CNT_W(CNT_W), .PERIOD_INIT(PERIOD_INIT)
  ) u_count (
    .clk(clk), .rstN(rstN), .tick(tick), .cmd(cmd), .period(period),
    .cnt(cnt), .expire(expire)
  );
endmodule

// File: tb/sentinel_wdt_bench.sv
`timescale 1ns/1ps
module sentinel_wdt_bench;
  localparam int INIT = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        busWe = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        smiReq, sysRst;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  sentinel_wdt #(.PERIOD_INIT(INIT)) u_sentinel_wdt (
    .clk(clk), .rstN(rstN), .tick(tick), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .smiReq(smiReq), .sysRst(sysRst)
  );

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      summary();
    end
  end

  task automatic wr(int addr, int data);
    @(negedge clk);
    busWe = 1'b1; busAddr = 5'(addr); busWdata = 16'(data);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(int addr, output int val);
    busAddr = 5'(addr);
    #0.5;
    val = busRdata;
  endtask

  // one tick; returns at the negedge after the edge that used it
  task automatic pulse();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) pulse();
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic t_reset();
    int v;
    rd('h00, v); check("R1 count", v, INIT);
    rd('h04, v); check("R1 period", v, INIT);
    rd('h0C, v); check("R1 control", v, 4);
    rd('h08, v); check("R1 status", v, 0);
    check("R1 smiReq", smiReq, 0);
    check("R1 sysRst", sysRst, 0);
  endtask

  task automatic t_countAndExpire();
    int v;
    wr('h04, 5);
    rd('h04, v); check("R11 period readback", v, 5);
    wr('h0C, 1);
    wr('h00, 0);
    rd('h00, v); check("R8 kick loads period", v, 5);
    ticks(3);
    rd('h00, v); check("R2 decrement", v, 2);
    ticks(2);
    rd('h00, v); check("R2 at zero", v, 0);
    check("R4 no early smi", smiReq, 0);
    pulse();
    check("R4 smi on expiry", smiReq, 1);
    rd('h00, v); check("R3 reload on expiry", v, 5);
    rd('h08, v); check("R5 flag set", v, 1);
    @(negedge clk);
    check("R4 smi one cycle", smiReq, 0);
    wr('h08, 0);
    rd('h08, v); check("R5 write 0 keeps flag", v, 1);
    wr('h08, 1);
    rd('h08, v); check("R5 write 1 clears", v, 0);
  endtask

  task automatic t_secondExpiry();
    wr('h00, 0);
    ticks(6);
    check("R6 no reset after first", sysRst, 0);
    ticks(6);
    check("R6 reset after second", sysRst, 1);
    wr('h00, 0);
    repeat (5) @(negedge clk);
    check("R6 reset sticky", sysRst, 1);
    doReset();
    check("R6 cleared by rstN", sysRst, 0);
  endtask

  task automatic t_kickClears();
    int v;
    wr('h04, 3);
    wr('h0C, 0);
    wr('h00, 0);
    ticks(4);
    check("R4 smi gated off", smiReq, 0);
    rd('h08, v); check("R5 flag on first", v, 1);
    wr('h00, 0);
    rd('h08, v); check("R8 kick clears flag", v, 0);
    ticks(4);
    rd('h08, v); check("R8 expiry is first again", v, 1);
    check("R8 no reset", sysRst, 0);
    wr('h08, 1);
  endtask

  task automatic t_noReboot();
    int v;
    wr('h0C, 3);
    wr('h00, 0);
    ticks(8);
    check("R7 reset suppressed", sysRst, 0);
    rd('h08, v); check("R7 flag still set", v, 1);
    wr('h08, 1);
  endtask

  task automatic t_halt();
    int v;
    wr('h0C, 5);
    wr('h00, 0);
    for (int i = 0; i < 10; i++) begin
      pulse();
      if (smiReq) check("R9 no smi while halted", 1, 0);
    end
    rd('h00, v); check("R9 count frozen", v, 3);
    rd('h08, v); check("R9 no expiry", v, 0);
  endtask

  task automatic t_race();
    int v;
    wr('h04, 2);
    wr('h0C, 1);
    wr('h00, 0);
    ticks(2);
    rd('h00, v); check("R10 at zero", v, 0);
    @(negedge clk);
    busWe = 1'b1; busAddr = 5'h00; busWdata = '0; tick = 1'b1;
    @(negedge clk);
    busWe = 1'b0; tick = 1'b0;
    check("R10 no smi", smiReq, 0);
    rd('h00, v); check("R10 reloaded", v, 2);
    rd('h08, v); check("R10 flag clear", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_countAndExpire();
    t_secondExpiry();
    t_kickClears();
    t_noReboot();
    t_halt();
    t_race();
    summary();
  end
endmodule